// File: doc/BRIEF.md
# Radix-3 Parallel Prefix Adder

This block adds two unsigned operands and a carry-in, and returns the sum and the carry-out. It is a parallel prefix adder. Each merge joins three adjacent groups, so the span of a group triples at every level: 3, 9, 27, and then the full width. Every carry is resolved in parallel. Each sum bit is formed directly from a partial sum that is computed once, at the start.

The carry-in acts as the generate term of an extra position below bit 0, and that position has no propagate. A group that reaches this position therefore already holds a complete prefix. Positions near the bottom whose reach would go below that position use a two-input merge or a pass-through instead.

The first merge level reads the operand bits directly, with no separate bitwise stage before it. The last merge level forms group generate only. The final XOR stage brings the depth to five logic levels at the default width of 64. An optional output register sits after the adder, is on by default, and clears on reset.

Top module: `prefix3Adder`

## Requirements
- R1: `sumOut` equals the low WIDTH bits of opA + opB + carryIn, taken as unsigned numbers.
- R2: `carryOut` equals bit WIDTH of opA + opB + carryIn. This bit is the carry out of the most significant position.
- R3: With both operands zero, `sumOut` equals carryIn in bit 0 and zeros elsewhere, and `carryOut` is 0.
- R4: When opA XOR opB is all ones, the result depends on carryIn:
  - With carryIn = 1, `sumOut` is all zeros and `carryOut` is 1, because the carry ripples through every position.
  - With carryIn = 0, `sumOut` is all ones and `carryOut` is 0.
- R5: A carry generated at any bit k reaches `carryOut` through every level of the tree. The test vector is opA = all ones from bit k upward and opB = only bit k set. For each k from 0 to WIDTH-1, this gives `sumOut` = 0 and `carryOut` = 1.
- R6: With REGISTER_OUT = 1, which is the default, the result for the operands sampled at a rising clock edge appears on the outputs after that edge. The result holds until the next edge.
- R7: While rstN is low at a rising edge, both outputs read zero after that edge.
- R8: The outputs match the arithmetic reference for arbitrary operand and carry-in values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output register |
| rstN | input | 1 | Active-low synchronous reset of the output register |
| opA | input | WIDTH | First operand |
| opB | input | WIDTH | Second operand |
| carryIn | input | 1 | Carry into bit 0 |
| sumOut | output | WIDTH | Sum, registered when REGISTER_OUT = 1 |
| carryOut | output | 1 | Carry out of the top bit, registered when REGISTER_OUT = 1 |

## Verification
Two effects can land in the same cycle: a carry injected through carryIn, and a carry generated inside the operands, can both need to travel the full prefix tree to the top position. The bench provokes this with a fully propagating operand pair and carryIn = 1. It also places a single generate bit at each of the 64 positions under an all-propagate upper field. Some of those positions fall on group boundaries of spans 3, 9 and 27. The bench judges each vector by comparing the registered sum and carry-out against a 65-bit arithmetic reference, one clock edge after the operands are driven.

// File: rtl/prefix3_pkg.sv
package prefix3_pkg;

  // 3 raised to a non-negative power
  function automatic int pow3(input int k);
    int r;
    r = 1;
    for (int i = 0; i < k; i++) r = r * 3;
    return r;
  endfunction

  // number of three-way merge levels needed for groups to cover n positions
  function automatic int levelsFor(input int n);
    int span;
    int l;
    span = 1;
    l = 0;
    while (span < n) begin
      span = span * 3;
      l = l + 1;
    end
    return l;
  endfunction

  // three-way generate merge, index 2 is the most significant subgroup
  function automatic logic mergeG3(input logic g2, input logic p2, input logic g1,
                                   input logic p1, input logic g0);
    return g2 | (p2 & (g1 | (p1 & g0)));
  endfunction

  function automatic logic mergeG2(input logic g1, input logic p1, input logic g0);
    return g1 | (p1 & g0);
  endfunction

endpackage

// File: rtl/prefixTree.sv
module prefixTree
  import prefix3_pkg::*;
#(
  parameter int WIDTH = 64
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic             carryIn,
  output logic [WIDTH-1:0] sumD,
  output logic             carryD
);

  // position 0 is the carry-in slot, position j holds bit j-1
  localparam int POS    = WIDTH + 1;
  localparam int LEVELS = levelsFor(POS);

  logic gLvl [0:LEVELS][0:WIDTH];
  logic pLvl [0:LEVELS-1][0:WIDTH];
  logic [WIDTH-1:0] halfSum;

  assign halfSum = opA ^ opB;

  // bit terms feed straight into the first merge level
  assign gLvl[0][0] = carryIn;
  assign pLvl[0][0] = 1'b0;
  for (genvar j = 1; j <= WIDTH; j++) begin : gBit
    assign gLvl[0][j] = opA[j-1] & opB[j-1];
    assign pLvl[0][j] = opA[j-1] | opB[j-1];
  end

  for (genvar lvl = 1; lvl <= LEVELS; lvl++) begin : gLevel
    localparam int STRIDE = pow3(lvl - 1);
    for (genvar j = 0; j <= WIDTH; j++) begin : gNode
      if (j >= 2 * STRIDE) begin : gFull
        assign gLvl[lvl][j] = mergeG3(gLvl[lvl-1][j], pLvl[lvl-1][j],
                                      gLvl[lvl-1][j-STRIDE], pLvl[lvl-1][j-STRIDE],
                                      gLvl[lvl-1][j-2*STRIDE]);
        if (lvl < LEVELS) begin : gProp
          assign pLvl[lvl][j] = pLvl[lvl-1][j] & pLvl[lvl-1][j-STRIDE]
                              & pLvl[lvl-1][j-2*STRIDE];
        end
      end else if (j >= STRIDE) begin : gPair
        assign gLvl[lvl][j] = mergeG2(gLvl[lvl-1][j], pLvl[lvl-1][j],
                                      gLvl[lvl-1][j-STRIDE]);
        if (lvl < LEVELS) begin : gProp
          assign pLvl[lvl][j] = pLvl[lvl-1][j] & pLvl[lvl-1][j-STRIDE];
        end
      end else begin : gPass
        assign gLvl[lvl][j] = gLvl[lvl-1][j];
        if (lvl < LEVELS) begin : gProp
          assign pLvl[lvl][j] = pLvl[lvl-1][j];
        end
      end
    end
  end

  // final level: carry into bit i is the complete prefix at position i
  for (genvar i = 0; i < WIDTH; i++) begin : gSum
    assign sumD[i] = halfSum[i] ^ gLvl[LEVELS][i];
  end
  assign carryD = gLvl[LEVELS][WIDTH];

endmodule

// File: rtl/outStage.sv
module outStage #(
  parameter int WIDTH        = 64,
  parameter bit REGISTER_OUT = 1'b1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] sumD,
  input  logic             carryD,
  output logic [WIDTH-1:0] sumQ,
  output logic             carryQ
);

  if (REGISTER_OUT) begin : gReg
    always_ff @(posedge clk) begin
      if (!rstN) begin
        sumQ   <= '0;
        carryQ <= 1'b0;
      end else begin
        sumQ   <= sumD;
        carryQ <= carryD;
      end
    end

    // R7: reset clears the outputs
    p_reset_clear_r7: assert property (@(posedge clk)
      !rstN |=> (sumQ == '0 && carryQ == 1'b0));
  end else begin : gWire
    assign sumQ   = sumD;
    assign carryQ = carryD;
  end

endmodule

// File: rtl/prefix3Adder.sv
module prefix3Adder #(
  parameter int WIDTH        = 64,
  parameter bit REGISTER_OUT = 1'b1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic             carryIn,
  output logic [WIDTH-1:0] sumOut,
  output logic             carryOut
);

  logic [WIDTH-1:0] sumD;
  logic             carryD;

  prefixTree #(.WIDTH(WIDTH)) i_tree (
    .opA    (opA),
    .opB    (opB),
    .carryIn(carryIn),
    .sumD   (sumD),
    .carryD (carryD)
  );

  outStage #(.WIDTH(WIDTH), .REGISTER_OUT(REGISTER_OUT)) i_out (
    .clk   (clk),
    .rstN  (rstN),
    .sumD  (sumD),
    .carryD(carryD),
    .sumQ  (sumOut),
    .carryQ(carryOut)
  );

  if (REGISTER_OUT) begin : gChk
    logic [WIDTH:0] refTotal;
    assign refTotal = {1'b0, opA} + {1'b0, opB} + {{WIDTH{1'b0}}, carryIn};

    // R1 / R6: registered sum follows the arithmetic reference
    p_sum_ref_r1: assert property (@(posedge clk) disable iff (!rstN)
      $past(rstN) |-> (sumOut == $past(refTotal[WIDTH-1:0])));

    // R2: carry-out follows the arithmetic reference
    p_carry_ref_r2: assert property (@(posedge clk) disable iff (!rstN)
      $past(rstN) |-> (carryOut == $past(refTotal[WIDTH])));

    // R3: zero operands pass the carry-in through
    p_cin_only_r3: assert property (@(posedge clk) disable iff (!rstN)
      ($past(rstN) && $past(opA == '0 && opB == '0)) |->
        (sumOut == {{(WIDTH-1){1'b0}}, $past(carryIn)} && !carryOut));

    // R4: full ripple when every position propagates
    p_full_ripple_r4: assert property (@(posedge clk) disable iff (!rstN)
      ($past(rstN) && $past((opA ^ opB) == '1)) |->
        (carryOut == $past(carryIn) && sumOut == {WIDTH{!$past(carryIn)}}));
  end

endmodule

// File: tb/test_prefix3Adder.sv
module test_prefix3Adder;

  localparam int W = 64;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic [W-1:0] opA = '0;
  logic [W-1:0] opB = '0;
  logic         carryIn = 1'b0;
  logic [W-1:0] sumOut;
  logic         carryOut;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  prefix3Adder #(.WIDTH(W), .REGISTER_OUT(1'b1)) i_prefix3Adder (
    .clk(clk), .rstN(rstN), .opA(opA), .opB(opB), .carryIn(carryIn),
    .sumOut(sumOut), .carryOut(carryOut)
  );

  task automatic checkOut(input logic [W-1:0] expSum, input logic expCarry,
                          input string req);
    checks++;
    if (sumOut !== expSum || carryOut !== expCarry) begin
      errors++;
      $display("FAIL %s: got sum=%h cout=%b, expected sum=%h cout=%b",
               req, sumOut, carryOut, expSum, expCarry);
    end
  endtask

  // drive on a falling edge, result is registered at the next rising edge,
  // sample on the following falling edge
  task automatic addCheck(input logic [W-1:0] a, input logic [W-1:0] b,
                          input logic ci, input string req);
    logic [W:0] expTotal;
    expTotal = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, ci};
    @(negedge clk);
    opA = a; opB = b; carryIn = ci;
    @(negedge clk);
    checkOut(expTotal[W-1:0], expTotal[W], req);
  endtask

  task automatic testReset();
    // R7: outputs zero during reset
    @(negedge clk);
    checkOut('0, 1'b0, "R7 reset state");
    @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic testCarryInOnly();
    addCheck('0, '0, 1'b0, "R3 zero operands cin=0");
    addCheck('0, '0, 1'b1, "R3 zero operands cin=1");
  endtask

  task automatic testRipple();
    addCheck('1, '0, 1'b1, "R4 full ripple cin=1");
    addCheck('1, '0, 1'b0, "R4 all propagate cin=0");
    addCheck(64'h5555_5555_5555_5555, 64'hAAAA_AAAA_AAAA_AAAA, 1'b1, "R4 alternating ripple");
    addCheck('1, '1, 1'b1, "R2 all generate");
  endtask

  task automatic testTopGenerate();
    addCheck(64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000, 1'b0, "R5 msb generate");
    addCheck(64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000, 1'b1, "R2 msb generate cin");
  endtask

  task automatic testSingleGenerate();
    // R5: generate at bit k, propagate above it
    for (int k = 0; k < W; k++) begin
      logic [W-1:0] a;
      logic [W-1:0] b;
      a = ~((64'd1 << k) - 64'd1);
      b = 64'd1 << k;
      addCheck(a, b, 1'b0, "R5 generate at bit k");
    end
  endtask

  task automatic testLatency();
    // R6: result appears one edge after operands, held until the next edge
    @(negedge clk);
    opA = 64'd1000; opB = 64'd234; carryIn = 1'b0;
    @(posedge clk);
    #1;
    checkOut(64'd1234, 1'b0, "R6 after capture edge");
    opA = 64'd7; opB = 64'd8;
    #1;
    checkOut(64'd1234, 1'b0, "R6 held between edges");
    @(negedge clk);
    @(negedge clk);
    checkOut(64'd15, 1'b0, "R6 next result");
  endtask

  task automatic testRandom();
    for (int n = 0; n < 3000; n++) begin
      logic [W-1:0] a;
      logic [W-1:0] b;
      a = {$urandom, $urandom};
      b = {$urandom, $urandom};
      addCheck(a, b, 1'($urandom), "R8 random vector");
    end
    addCheck(64'hFFFF_FFFF_0000_0000, 64'h0000_0001_0000_0000, 1'b0, "R1 upper half carry");
  endtask

  task automatic testMidReset();
    addCheck('1, '1, 1'b1, "R1 before mid reset");
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    checkOut('0, 1'b0, "R7 mid-run reset");
    rstN = 1'b1;
  endtask

  initial begin
    testReset();
    testCarryInOnly();
    testRipple();
    testTopGenerate();
    testSingleGenerate();
    testLatency();
    testRandom();
    testMidReset();
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #500000;
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule